// File: doc/BRIEF.md
# Multi-Snapshot Fine-Time Averaging Accumulator

This block is the digital back end of a ring-oscillator time converter. An enable input marks one measurement window. While the window is open, the front end delivers one snapshot per reference clock of a large bank of two-bit Gray-coded tap counters. The block decodes every tap counter, adds the values of each snapshot in a pipelined adder tree, and sums up to a parameterised number of snapshots. The oscillator and the clock differ slightly in period, so each snapshot sees a shifted phase. The sum of the snapshots is therefore a fine code with the single-shot step divided by the snapshot count.

A four-bit Gray-coded coarse counter counts the clock cycles in the window. When the window closes, the block subtracts a signed drift correction from the accumulated fine code and clamps the result to the output range. It then emits a one-cycle record with the coarse count and the fine code. The drift correction stands for the oscillator-versus-clock period difference, prescaled by (N-1)/2, and is loaded through a single-cycle write strobe. If the window closes before the full snapshot count is collected, the block emits the partial sum and raises a short-measurement flag.

Top module: `wu_snap_avg`

## Requirements
- R1: After reset, out_vld, out_coarse, out_fine and out_short are 0 and the drift correction is 0. A measurement taken without any correction write reports the raw sum.
- R2: Each tap counter is decoded from Gray code as 00->0, 01->1, 11->2, 10->3. Tap i occupies tap_gray[2i+1:2i], and a snapshot's value is the sum over all taps.
- R3: A snapshot is taken in every clock cycle in which meas_en is sampled high. The fine sum is the sum of the first NSNAP snapshots of the window, and later snapshots in the same window have no effect on it.
- R4: A cycle with corr_we high loads corr_wdata (two's complement) as the drift correction. The emitted fine code is the sum minus that correction.
- R5: The corrected value is clamped to the range 0 to 2^FINE_W-1 (0 to 32767 by default).
- R6: out_coarse is the binary number of cycles meas_en was high in the window, modulo 16.
- R7: out_short is 1 exactly when fewer than NSNAP snapshots were taken. The fine code is then the partial sum of all snapshots taken.
- R8: out_vld pulses for one cycle and appears after the third rising edge counted from the first edge that samples meas_en low. Each new window restarts the sum and the coarse count, even after a single low cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| meas_en | input | 1 | Measurement window, synchronous to clk |
| tap_gray | input | 2*NTAPS | Snapshot of all two-bit Gray tap counters |
| corr_we | input | 1 | Load strobe for the drift correction |
| corr_wdata | input | CORR_W | Signed drift correction in effective LSB |
| out_vld | output | 1 | One-cycle result strobe |
| out_coarse | output | 4 | Binary coarse cycle count |
| out_fine | output | FINE_W | Corrected, clamped fine code |
| out_short | output | 1 | Window ended before NSNAP snapshots |

## Verification
The assertions assume that meas_en is synchronous, is low throughout reset, and stays low for at least one cycle between windows. They also assume that the correction is not rewritten in the cycles between a window closing and its record being emitted. The stimulus drives every input on the falling clock edge, keeps windows separated by at least one low cycle (one test uses exactly one to cover the restart), and writes the correction only while no window is open or draining.

// File: rtl/wu_snap_avg_pkg.sv
package wu_snap_avg_pkg;
    localparam int COARSE_W = 4;

    // Two-bit Gray tap code to binary value
    function automatic logic [1:0] tap_val(input logic [1:0] g);
        return {g[1], g[1] ^ g[0]};
    endfunction

    function automatic logic [COARSE_W-1:0] gray2bin(input logic [COARSE_W-1:0] g);
        logic [COARSE_W-1:0] b;
        b[COARSE_W-1] = g[COARSE_W-1];
        for (int i = COARSE_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    function automatic logic [COARSE_W-1:0] bin2gray(input logic [COARSE_W-1:0] b);
        return b ^ (b >> 1);
    endfunction
endpackage

// File: rtl/wu_tap_sum.sv
// First tree stage: decode taps and sum them in groups of GROUP.
module wu_tap_sum import wu_snap_avg_pkg::*; #(
    parameter int NTAPS = 1024,
    parameter int GROUP = 32,
    localparam int NGRP = NTAPS / GROUP,
    localparam int PART_W = $clog2(3 * GROUP + 1)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [2*NTAPS-1:0]             taps,
    input  logic                           vin,
    input  logic                           sin,
    output logic [NGRP-1:0][PART_W-1:0]    part,
    output logic                           vout,
    output logic                           sout
);
    typedef struct packed {
        logic [NGRP-1:0][PART_W-1:0] part;
        logic                        v;
        logic                        s;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        st_d.v = vin;
        st_d.s = sin;
        for (int g = 0; g < NGRP; g++) begin
            logic [PART_W-1:0] acc;
            acc = '0;
            for (int k = 0; k < GROUP; k++) begin
                acc = acc + {{(PART_W-2){1'b0}}, tap_val(taps[2*(g*GROUP+k) +: 2])};
            end
            st_d.part[g] = acc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign part = st_q.part;
    assign vout = st_q.v;
    assign sout = st_q.s;
endmodule

// File: rtl/wu_part_total.sv
// Second tree stage: add the group partials into one snapshot value.
module wu_part_total #(
    parameter int NGRP   = 32,
    parameter int PART_W = 7,
    parameter int SNAP_W = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NGRP-1:0][PART_W-1:0] part,
    input  logic                        vin,
    input  logic                        sin,
    output logic [SNAP_W-1:0]           total,
    output logic                        vout,
    output logic                        sout
);
    typedef struct packed {
        logic [SNAP_W-1:0] total;
        logic              v;
        logic              s;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.v     = vin;
        st_d.s     = sin;
        st_d.total = '0;
        for (int g = 0; g < NGRP; g++) begin
            st_d.total = st_d.total + {{(SNAP_W-PART_W){1'b0}}, part[g]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign total = st_q.total;
    assign vout  = st_q.v;
    assign sout  = st_q.s;
endmodule

// File: rtl/wu_snap_avg.sv
module wu_snap_avg import wu_snap_avg_pkg::*; #(
    parameter int NTAPS  = 1024,
    parameter int GROUP  = 32,
    parameter int NSNAP  = 16,
    parameter int FINE_W = 15,
    parameter int CORR_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                meas_en,
    input  logic [2*NTAPS-1:0]  tap_gray,
    input  logic                corr_we,
    input  logic [CORR_W-1:0]   corr_wdata,
    output logic                out_vld,
    output logic [COARSE_W-1:0] out_coarse,
    output logic [FINE_W-1:0]   out_fine,
    output logic                out_short
);
    localparam int NGRP   = NTAPS / GROUP;
    localparam int PART_W = $clog2(3 * GROUP + 1);
    localparam int SNAP_W = $clog2(3 * NTAPS + 1);
    localparam int ACC_W  = SNAP_W + $clog2(NSNAP + 1);
    localparam int CNT_W  = $clog2(NSNAP + 1);
    // Difference width: one bit above the wider operand plus sign, and wider than FINE_W
    localparam int DW0    = ((ACC_W > CORR_W) ? ACC_W : CORR_W) + 2;
    localparam int DW     = (DW0 > FINE_W + 1) ? DW0 : FINE_W + 2;
    localparam logic [CNT_W-1:0] N_C    = CNT_W'(NSNAP);
    localparam logic [DW-1:0]    FMAX_X = {{(DW-FINE_W){1'b0}}, {FINE_W{1'b1}}};

    typedef struct packed {
        logic                     en;
        logic                     v3;
        logic [ACC_W-1:0]         acc;
        logic [CNT_W-1:0]         cnt;
        logic [COARSE_W-1:0]      cg;
        logic [CORR_W-1:0]        corr;
        logic                     ovld;
        logic [COARSE_W-1:0]      ocoarse;
        logic [FINE_W-1:0]        ofine;
        logic                     oshort;
    } st_t;

    st_t st_d, st_q;

    logic [NGRP-1:0][PART_W-1:0] part;
    logic                        v1, s1, v2, s2;
    logic [SNAP_W-1:0]           total;
    logic [DW-1:0]               diff;

    wu_tap_sum #(.NTAPS(NTAPS), .GROUP(GROUP)) u_part (
        .clk(clk), .rst_n(rst_n), .taps(tap_gray),
        .vin(meas_en), .sin(meas_en & ~st_q.en),
        .part(part), .vout(v1), .sout(s1)
    );

    wu_part_total #(.NGRP(NGRP), .PART_W(PART_W), .SNAP_W(SNAP_W)) u_tot (
        .clk(clk), .rst_n(rst_n), .part(part), .vin(v1), .sin(s1),
        .total(total), .vout(v2), .sout(s2)
    );

    always_comb begin
        st_d      = st_q;
        st_d.en   = meas_en;
        st_d.v3   = v2;
        st_d.ovld = 1'b0;
        if (corr_we) st_d.corr = corr_wdata;

        // Window start clears; later snapshots add until NSNAP are taken
        if (s2) begin
            st_d.acc = {{(ACC_W-SNAP_W){1'b0}}, total};
            st_d.cnt = CNT_W'(1);
            st_d.cg  = bin2gray(COARSE_W'(1));
        end else if (v2) begin
            st_d.cg = bin2gray(gray2bin(st_q.cg) + COARSE_W'(1));
            if (st_q.cnt < N_C) begin
                st_d.acc = st_q.acc + {{(ACC_W-SNAP_W){1'b0}}, total};
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end

        diff = {{(DW-ACC_W){1'b0}}, st_q.acc}
             - {{(DW-CORR_W){st_q.corr[CORR_W-1]}}, st_q.corr};

        // Window end reaches the accumulator: emit the record
        if (!v2 && st_q.v3) begin
            st_d.ovld    = 1'b1;
            st_d.ocoarse = gray2bin(st_q.cg);
            st_d.oshort  = (st_q.cnt < N_C);
            if (diff[DW-1])          st_d.ofine = '0;
            else if (diff > FMAX_X)  st_d.ofine = '1;
            else                     st_d.ofine = diff[FINE_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_vld    = st_q.ovld;
    assign out_coarse = st_q.ocoarse;
    assign out_fine   = st_q.ofine;
    assign out_short  = st_q.oshort;
endmodule

// File: rtl/wu_snap_avg_chk.sv
module wu_snap_avg_chk #(
    parameter int NSNAP  = 16,
    parameter int CORR_W = 16,
    parameter int CNT_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              meas_en,
    input logic              corr_we,
    input logic [CORR_W-1:0] corr_wdata,
    input logic [CORR_W-1:0] corr_q,
    input logic [CNT_W-1:0]  cnt_q,
    input logic              out_vld,
    input logic              out_short
);
    localparam logic [CNT_W-1:0] N_C = CNT_W'(NSNAP);

    AST_CORR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        corr_we |=> corr_q == $past(corr_wdata)); // R4
    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= N_C); // R3
    AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |=> !out_vld); // R8
    AST_VLD_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> !$past(meas_en, 3)); // R8
    AST_SHORT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> out_short == ($past(cnt_q) < N_C)); // R7
endmodule

bind wu_snap_avg wu_snap_avg_chk #(
    .NSNAP(NSNAP), .CORR_W(CORR_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .meas_en(meas_en), .corr_we(corr_we),
    .corr_wdata(corr_wdata), .corr_q(st_q.corr), .cnt_q(st_q.cnt),
    .out_vld(out_vld), .out_short(out_short)
);

// File: tb/sim_wu_snap_avg.sv
module sim_wu_snap_avg;
    localparam int NT     = 1024;
    localparam int NSNAP  = 16;
    localparam int FINE_W = 15;
    localparam int CORR_W = 16;
    localparam int FMAX   = (1 << FINE_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              meas_en = 1'b0;
    logic [2*NT-1:0]   tap_gray = '0;
    logic              corr_we = 1'b0;
    logic [CORR_W-1:0] corr_wdata = '0;
    logic              out_vld;
    logic [3:0]        out_coarse;
    logic [FINE_W-1:0] out_fine;
    logic              out_short;

    int errors = 0;
    int checks = 0;
    int corr_now = 0;
    bit done = 0;

    int cap_n = 0;
    int cap_fine [16];
    int cap_coarse [16];
    bit cap_short [16];

    always #5 clk = ~clk;

    wu_snap_avg u0 (
        .clk(clk), .rst_n(rst_n), .meas_en(meas_en), .tap_gray(tap_gray),
        .corr_we(corr_we), .corr_wdata(corr_wdata), .out_vld(out_vld),
        .out_coarse(out_coarse), .out_fine(out_fine), .out_short(out_short)
    );

    always @(negedge clk) begin
        if (out_vld) begin
            cap_fine[cap_n % 16]   = int'(out_fine);
            cap_coarse[cap_n % 16] = int'(out_coarse);
            cap_short[cap_n % 16]  = out_short;
            cap_n++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Bench-side decoder from the R2 code table
    function automatic int snap_val(input logic [2*NT-1:0] v);
        int s = 0;
        for (int i = 0; i < NT; i++) begin
            case (v[2*i +: 2])
                2'b00: s += 0;
                2'b01: s += 1;
                2'b11: s += 2;
                default: s += 3;
            endcase
        end
        return s;
    endfunction

    function automatic logic [2*NT-1:0] mk(input int kind, input int base, input int c);
        logic [2*NT-1:0] v = '0;
        int lim = (base + 37 * c) % (NT + 1);
        logic [1:0] gtab [4] = '{2'b00, 2'b01, 2'b11, 2'b10};
        if (kind == 2) lim = NT;
        for (int i = 0; i < NT; i++) begin
            if (i < lim) begin
                if (kind == 0)      v[2*i +: 2] = 2'b01;
                else if (kind == 1) v[2*i +: 2] = gtab[(i + c) % 4];
                else                v[2*i +: 2] = 2'b10;
            end
        end
        return v;
    endfunction

    function automatic int clampv(input int raw);
        int e = raw - corr_now;
        if (e < 0) e = 0;
        if (e > FMAX) e = FMAX;
        return e;
    endfunction

    // Opens a window of len cycles, then drives meas_en low on the next falling edge
    task automatic run_meas(input int kind, input int base, input int len, output int raw);
        raw = 0;
        for (int c = 0; c < len; c++) begin
            @(negedge clk);
            meas_en  = 1'b1;
            tap_gray = mk(kind, base, c);
            if (c < NSNAP) raw += snap_val(tap_gray);
        end
        @(negedge clk);
        meas_en  = 1'b0;
        tap_gray = mk(2, 0, 0); // taps busy after the window: must not matter
    endtask

    task automatic write_corr(input int val);
        @(negedge clk);
        corr_we    = 1'b1;
        corr_wdata = CORR_W'(val);
        @(negedge clk);
        corr_we    = 1'b0;
        corr_now   = val;
    endtask

    task automatic expect_one(input string req, input int kind, input int base, input int len);
        int raw;
        int n0 = cap_n;
        run_meas(kind, base, len, raw);
        repeat (4) @(negedge clk);
        chk({req, " record count"}, cap_n - n0, 1);
        chk({req, " fine"}, cap_fine[(cap_n - 1) % 16], clampv(raw));
        chk({req, " coarse"}, cap_coarse[(cap_n - 1) % 16], len % 16);
        chk({req, " short"}, int'(cap_short[(cap_n - 1) % 16]), (len < NSNAP) ? 1 : 0);
    endtask

    task automatic t_reset();
        chk("R1 out_vld", int'(out_vld), 0);
        chk("R1 out_fine", int'(out_fine), 0);
        chk("R1 out_coarse", int'(out_coarse), 0);
        chk("R1 out_short", int'(out_short), 0);
    endtask

    task automatic t_full();
        // no correction written yet (R1); first NSNAP of 20 snapshots count (R3, R6)
        expect_one("R1 R3 R6 plain 20-cycle window", 0, 50, 20);
    endtask

    task automatic t_mixed();
        expect_one("R2 mixed Gray taps", 1, 200, 16);
        expect_one("R2 all taps code 10", 2, 0, 3);
    endtask

    task automatic t_short();
        expect_one("R7 short window", 0, 90, 5);
        expect_one("R7 one-cycle window", 1, 400, 1);
    endtask

    task automatic t_corr();
        write_corr(1000);
        expect_one("R4 positive correction", 0, 300, 16);
        write_corr(-500);
        expect_one("R4 negative correction", 1, 120, 16);
    endtask

    task automatic t_clamp();
        write_corr(30000);
        expect_one("R5 clamp to zero", 0, 10, 2);
        write_corr(0);
        expect_one("R5 clamp to max", 2, 0, 16);
    endtask

    task automatic t_coarse();
        expect_one("R6 coarse wrap 17", 0, 5, 17);
        expect_one("R6 coarse 16", 0, 5, 16);
    endtask

    task automatic t_timing();
        int raw_a, raw_b;
        int n0;
        run_meas(0, 30, 4, raw_a);
        @(negedge clk); chk("R8 no valid 1 cycle after low", int'(out_vld), 0);
        @(negedge clk); chk("R8 no valid 2 cycles after low", int'(out_vld), 0);
        @(negedge clk); chk("R8 valid 3 cycles after low", int'(out_vld), 1);
        @(negedge clk); chk("R8 valid is one pulse", int'(out_vld), 0);
        repeat (2) @(negedge clk);
        // Back-to-back windows with a single low cycle
        n0 = cap_n;
        run_meas(2, 0, 3, raw_a);
        run_meas(0, 70, 4, raw_b);
        repeat (5) @(negedge clk);
        chk("R8 two records", cap_n - n0, 2);
        chk("R8 first fine", cap_fine[n0 % 16], clampv(raw_a));
        chk("R8 restart fine", cap_fine[(n0 + 1) % 16], clampv(raw_b));
        chk("R8 restart coarse", cap_coarse[(n0 + 1) % 16], 4);
    endtask

    initial begin
        #(10 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_full();
        t_mixed();
        t_short();
        t_corr();
        t_clamp();
        t_coarse();
        t_timing();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule